// File: doc/BRIEF.md
# NAND Page Hamming ECC Generator

This block computes an error-detecting and single-bit-correcting Hamming code over the data of a NAND flash page while the bytes stream past, one byte per strobe. Each chunk of 256 bytes (2048 bits) produces two 11-bit parity words. Every data bit has an 11-bit position number, equal to its byte index within the chunk times eight plus its bit index. The "odd" word collects the parity of the bits whose position has a given bit set. The "even" word collects the parity of the bits whose position has that bit clear.

A mode input chooses between two page lengths. The short page has one chunk of 256 bytes. The long page has two chunks, 512 bytes in all. In the long page the second chunk's code goes to a second pair of result registers. The controller pulses a clear input before each page transfer. The results are final when the done flag rises. A correction routine can pack a chunk's words as odd | (even << 11), which gives 22 bits stored as three little-endian bytes. When exactly one data bit is flipped, the odd-word syndrome gives the position of that bit, and the odd and even syndromes XOR to all ones.

Top module: `nand_ecc_gen`

## Requirements
- R1: Bit k of an odd word (ecc0_o for chunk 0, ecc2_o for chunk 1) is the XOR of every data bit in that chunk whose position (byte_index*8 + bit_index, with byte_index 0..255 inside the chunk) has bit k set.
- R2: Bit k of an even word (ecc1_o for chunk 0, ecc3_o for chunk 1) is the XOR of every data bit in that chunk whose position has bit k clear.
- R3: Bytes 0..255 of a page feed only ecc0_o and ecc1_o.
- R4: With wide_page=1, bytes 256..511 feed only ecc2_o and ecc3_o.
- R5: With wide_page=0, a page is 256 bytes, and ecc2_o and ecc3_o stay zero.
- R6: page_done stays low until the final byte of the selected page length is taken. It is high in the cycle after that byte's strobe, and ecc0_o..ecc3_o hold their final values in that same cycle.
- R7: While page_done is high, strobed bytes have no effect on ecc0_o..ecc3_o, and page_done stays high until a clear.
- R8: After rst or an ecc_clr pulse, ecc0_o..ecc3_o read zero and page_done reads zero. ecc_clr wins over a strobe in the same cycle, and that byte is dropped.
- R9: Flipping one data bit at byte B, bit b of a chunk changes that chunk's odd word by exactly B*8+b. The odd-word change XORed with the even-word change is 0x7FF.
- R10: Cycles without byte_vld do not advance the byte position and do not change any result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_clr | input | 1 | Single-cycle pulse that starts a new page |
| wide_page | input | 1 | 0: 256-byte page, 1: 512-byte page; held stable during a page |
| byte_vld | input | 1 | Byte strobe |
| byte_data | input | 8 | Data byte |
| ecc0_o | output | 11 | Odd parity word, chunk 0 |
| ecc1_o | output | 11 | Even parity word, chunk 0 |
| ecc2_o | output | 11 | Odd parity word, chunk 1 |
| ecc3_o | output | 11 | Even parity word, chunk 1 |
| page_done | output | 1 | Results are final |

## Verification
The embedded properties check on every cycle that a clear empties all four words and drops page_done, that page_done holds once set, and that the words freeze while it is high. They also check that no more than one chunk register takes a byte in any cycle, and that the two byte terms are always complementary under the byte's parity. The actual parity values are not checked by any property: the position mapping, the split of a long page into its two chunks, the done timing with gaps between strobes, and the single-flip syndrome property appear only in the bench's scenarios. There, a reference model computed bit by bit is compared against the outputs.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  // Page sequencer state: still collecting bytes, or page complete
  typedef enum logic [0:0] {
    SEQ_COLLECT = 1'b0,
    SEQ_FULL    = 1'b1
  } seq_state_t;

endpackage

// File: rtl/nand_ecc_term.sv
// Combinational parity contribution of one byte at a given index in a chunk.
module nand_ecc_term #(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 8,
  localparam int BIT_W = $clog2(BYTE_W),
  localparam int POS_W = BIT_W + IDX_W
) (
  input  logic [BYTE_W-1:0] data_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [POS_W-1:0]  odd_o,
  output logic [POS_W-1:0]  even_o
);

  logic par;

  always_comb begin
    odd_o  = '0;
    even_o = '0;
    par    = ^data_i;
    // low position bits come from the bit index inside the byte
    for (int b = 0; b < BYTE_W; b++) begin
      for (int k = 0; k < BIT_W; k++) begin
        if (b[k]) odd_o[k]  = odd_o[k]  ^ data_i[b];
        else      even_o[k] = even_o[k] ^ data_i[b];
      end
    end
    // upper position bits come from the byte index: whole-byte parity
    for (int k = 0; k < IDX_W; k++) begin
      odd_o[BIT_W+k]  = idx_i[k] & par;
      even_o[BIT_W+k] = ~idx_i[k] & par;
    end
  end

  // R2: each position bit is either set or clear, so the two terms
  // together cover the byte exactly once per word bit
  always_comb begin
    a_r2_term_complement: assert ((odd_o ^ even_o) == {POS_W{par}});
  end

endmodule

// File: rtl/nand_ecc_accum.sv
// One chunk's pair of parity registers.
module nand_ecc_accum #(
  parameter int POS_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [POS_W-1:0] odd_term_i,
  input  logic [POS_W-1:0] even_term_i,
  output logic [POS_W-1:0] odd_q,
  output logic [POS_W-1:0] even_q
);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      odd_q  <= '0;
      even_q <= '0;
    end else if (en_i) begin
      odd_q  <= odd_q  ^ odd_term_i;
      even_q <= even_q ^ even_term_i;
    end
  end

  // R10: a chunk without an enable keeps its words
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !clr_i) |=> ($stable(odd_q) && $stable(even_q)));

endmodule

// File: rtl/nand_ecc_seq.sv
// Byte position counter, chunk selection and the page-complete flag.
module nand_ecc_seq
  import nand_ecc_pkg::*;
#(
  parameter int CHUNK_BYTES = 256,
  parameter int MAX_CHUNKS  = 2,
  localparam int IDX_W = $clog2(CHUNK_BYTES),
  localparam int SEL_W = (MAX_CHUNKS > 1) ? $clog2(MAX_CHUNKS) : 1,
  localparam int CNT_W = IDX_W + SEL_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr_i,
  input  logic                  wide_i,
  input  logic                  vld_i,
  output logic [IDX_W-1:0]      idx_o,
  output logic [MAX_CHUNKS-1:0] chunk_en_o,
  output logic                  done_o
);

  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(CHUNK_BYTES - 1);
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(CHUNK_BYTES * MAX_CHUNKS - 1);

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_pos;
  logic [SEL_W-1:0] sel;
  logic             take;

  assign last_pos = wide_i ? LAST_WIDE : LAST_NARROW;
  assign take     = vld_i && !clr_i && (state_q == SEQ_COLLECT);
  assign idx_o    = cnt_q[IDX_W-1:0];
  assign sel      = cnt_q[CNT_W-1:IDX_W];
  assign done_o   = (state_q == SEQ_FULL);

  for (genvar c = 0; c < MAX_CHUNKS; c++) begin : g_en
    assign chunk_en_o[c] = take && (sel == SEL_W'(c));
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      state_q <= SEQ_COLLECT;
      cnt_q   <= '0;
    end else if (take) begin
      if (cnt_q == last_pos) state_q <= SEQ_FULL;
      else                   cnt_q   <= cnt_q + 1'b1;
    end
  end

  // R7: the page flag holds until a clear
  a_r7_done_holds: assert property (@(posedge clk) disable iff (rst)
    (done_o && !clr_i) |=> done_o);

  // R3: at most one chunk register takes a byte per cycle
  a_r3_one_chunk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chunk_en_o));

  // R7: no chunk is enabled once the page is complete
  a_r7_no_take_when_done: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (chunk_en_o == '0));

  // R10: no strobe, no enable
  a_r10_no_strobe_no_en: assert property (@(posedge clk) disable iff (rst)
    !vld_i |-> (chunk_en_o == '0));

endmodule

// File: rtl/nand_ecc_gen.sv
// Streaming Hamming code generator for 256- or 512-byte NAND pages.
module nand_ecc_gen #(
  parameter int CHUNK_BYTES = 256,
  parameter int BYTE_W      = 8,
  localparam int MAX_CHUNKS = 2,
  localparam int IDX_W      = $clog2(CHUNK_BYTES),
  localparam int ECC_W      = $clog2(BYTE_W) + IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ecc_clr,
  input  logic              wide_page,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  output logic [ECC_W-1:0]  ecc0_o,
  output logic [ECC_W-1:0]  ecc1_o,
  output logic [ECC_W-1:0]  ecc2_o,
  output logic [ECC_W-1:0]  ecc3_o,
  output logic              page_done
);

  logic [IDX_W-1:0]      idx;
  logic [MAX_CHUNKS-1:0] chunk_en;
  logic [ECC_W-1:0]      odd_term, even_term;
  logic [ECC_W-1:0]      odd_w  [MAX_CHUNKS];
  logic [ECC_W-1:0]      even_w [MAX_CHUNKS];

  nand_ecc_seq #(
    .CHUNK_BYTES(CHUNK_BYTES),
    .MAX_CHUNKS (MAX_CHUNKS)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (ecc_clr),
    .wide_i    (wide_page),
    .vld_i     (byte_vld),
    .idx_o     (idx),
    .chunk_en_o(chunk_en),
    .done_o    (page_done)
  );

  nand_ecc_term #(
    .BYTE_W(BYTE_W),
    .IDX_W (IDX_W)
  ) u_term (
    .data_i(byte_data),
    .idx_i (idx),
    .odd_o (odd_term),
    .even_o(even_term)
  );

  for (genvar c = 0; c < MAX_CHUNKS; c++) begin : g_chunk
    nand_ecc_accum #(
      .POS_W(ECC_W)
    ) u_acc (
      .clk        (clk),
      .rst        (rst),
      .clr_i      (ecc_clr),
      .en_i       (chunk_en[c]),
      .odd_term_i (odd_term),
      .even_term_i(even_term),
      .odd_q      (odd_w[c]),
      .even_q     (even_w[c])
    );
  end

  assign ecc0_o = odd_w[0];
  assign ecc1_o = even_w[0];
  assign ecc2_o = odd_w[1];
  assign ecc3_o = even_w[1];

  // R8: a clear empties every word and drops the flag
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (rst)
    ecc_clr |=> (ecc0_o == '0 && ecc1_o == '0 && ecc2_o == '0 &&
                 ecc3_o == '0 && !page_done));

  // R7: results frozen while the page is complete
  a_r7_frozen_when_done: assert property (@(posedge clk) disable iff (rst)
    (page_done && !ecc_clr) |=> ($stable(ecc0_o) && $stable(ecc1_o) &&
                                 $stable(ecc2_o) && $stable(ecc3_o)));

endmodule

// File: tb/tb_nand_ecc_gen.sv
module tb_nand_ecc_gen;

  localparam int W = 11;

  typedef struct packed {
    logic [W-1:0] e0, e1, e2, e3;
  } exp_t;

  logic clk = 1'b0;
  logic rst, ecc_clr, wide_page, byte_vld;
  logic [7:0] byte_data;
  logic [W-1:0] ecc0_o, ecc1_o, ecc2_o, ecc3_o;
  logic page_done;

  int n_chk  = 0;
  int n_fail = 0;
  exp_t sb_q[$];
  logic [7:0] pg [512];

  always #10 clk = ~clk;   // 50 MHz

  nand_ecc_gen dut (
    .clk(clk), .rst(rst), .ecc_clr(ecc_clr), .wide_page(wide_page),
    .byte_vld(byte_vld), .byte_data(byte_data),
    .ecc0_o(ecc0_o), .ecc1_o(ecc1_o), .ecc2_o(ecc2_o), .ecc3_o(ecc3_o),
    .page_done(page_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Reference: bit-by-bit parity over one chunk, returns {even, odd}
  function automatic logic [2*W-1:0] ref_chunk(input int base);
    logic [W-1:0] od, ev;
    od = '0; ev = '0;
    for (int bi = 0; bi < 256; bi++)
      for (int b = 0; b < 8; b++)
        if (pg[base+bi][b]) begin
          int pos;
          pos = bi * 8 + b;
          for (int k = 0; k < W; k++)
            if (pos[k]) od[k] = ~od[k]; else ev[k] = ~ev[k];
        end
    return {ev, od};
  endfunction

  // Monitor: on each rise of page_done, pop and compare
  logic done_seen = 1'b0;
  always @(negedge clk) begin
    if (page_done && !done_seen) begin
      exp_t e;
      if (sb_q.size() == 0) begin
        chk("R6 unexpected done", 32'd1, 32'd0);
      end else begin
        e = sb_q.pop_front();
        chk("R1 odd word chunk0", 32'(ecc0_o), 32'(e.e0));
        chk("R2 even word chunk0", 32'(ecc1_o), 32'(e.e1));
        chk("R4/R5 odd word chunk1", 32'(ecc2_o), 32'(e.e2));
        chk("R4/R5 even word chunk1", 32'(ecc3_o), 32'(e.e3));
      end
    end
    done_seen <= page_done;
  end

  task automatic pulse_clr();
    @(negedge clk); ecc_clr = 1'b1;
    @(negedge clk); ecc_clr = 1'b0;
  endtask

  // Driver: push expected item, stream the page, optional idle gaps
  task automatic run_page(input bit wide, input int gap_mod);
    int n;
    exp_t e;
    logic [2*W-1:0] c0, c1;
    n = wide ? 512 : 256;
    wide_page = wide;
    pulse_clr();
    c0 = ref_chunk(0);
    c1 = wide ? ref_chunk(256) : '0;
    e.e0 = c0[W-1:0]; e.e1 = c0[2*W-1:W];
    e.e2 = c1[W-1:0]; e.e3 = c1[2*W-1:W];
    sb_q.push_back(e);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == n - 1) chk("R6 done low before final byte", 32'(page_done), 32'd0);
      byte_vld = 1'b1; byte_data = pg[i];
      if (gap_mod != 0 && (i % gap_mod) == 0) begin
        @(negedge clk); byte_vld = 1'b0; byte_data = 8'hA5;  // R10 idle
        @(negedge clk);
      end
    end
    @(negedge clk);
    byte_vld = 1'b0;
    chk("R6 done high after final byte", 32'(page_done), 32'd1);
    @(negedge clk);
  endtask

  task automatic fill_random();
    for (int i = 0; i < 512; i++) pg[i] = 8'($urandom);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog expired", 32'd1, 32'd0);
    finish_up();
  end

  initial begin
    logic [W-1:0] o0, h0;
    rst = 1'b1; ecc_clr = 1'b0; wide_page = 1'b0; byte_vld = 1'b0; byte_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    chk("R8 reset ecc0", 32'(ecc0_o), 32'd0);
    chk("R8 reset ecc3", 32'(ecc3_o), 32'd0);
    chk("R8 reset done", 32'(page_done), 32'd0);

    // R5: all-zero narrow page
    for (int i = 0; i < 512; i++) pg[i] = 8'h00;
    run_page(1'b0, 0);

    // R1 R2 R9: single set bit at byte 0x5A bit 3 -> position 0x2D3
    pg[8'h5A] = 8'h08;
    run_page(1'b0, 0);
    chk("R1 single bit position", 32'(ecc0_o), 32'h2D3);
    chk("R2 single bit complement", 32'(ecc1_o), 32'h52C);
    chk("R9 halves xor to all ones", 32'(ecc0_o ^ ecc1_o), 32'h7FF);

    // R1 R2 R3 R5: random narrow pages
    for (int r = 0; r < 3; r++) begin
      fill_random();
      run_page(1'b0, 0);
    end

    // R4: random wide pages
    for (int r = 0; r < 3; r++) begin
      fill_random();
      run_page(1'b1, 0);
    end

    // R10: strobes with gaps
    fill_random();
    run_page(1'b1, 7);
    fill_random();
    run_page(1'b0, 3);

    // R9: flip one bit in a random narrow page
    fill_random();
    run_page(1'b0, 0);
    o0 = ecc0_o; h0 = ecc1_o;
    pg[200] = pg[200] ^ 8'h40;   // byte 200 bit 6 -> 1606
    run_page(1'b0, 0);
    chk("R9 odd syndrome equals position", 32'(o0 ^ ecc0_o), 32'd1606);
    chk("R9 syndrome halves xor to 0x7FF", 32'((o0 ^ ecc0_o) ^ (h0 ^ ecc1_o)), 32'h7FF);

    // R9 in chunk 1 of a wide page: byte 256+17 bit 1 -> 137
    fill_random();
    run_page(1'b1, 0);
    o0 = ecc2_o; h0 = ecc3_o;
    pg[273] = pg[273] ^ 8'h02;
    run_page(1'b1, 0);
    chk("R9 chunk1 syndrome position", 32'(o0 ^ ecc2_o), 32'd137);
    chk("R9 chunk1 halves", 32'((o0 ^ ecc2_o) ^ (h0 ^ ecc3_o)), 32'h7FF);

    // R7: bytes after done are ignored
    o0 = ecc0_o; h0 = ecc1_o;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); byte_vld = 1'b1; byte_data = 8'hFF;
    end
    @(negedge clk); byte_vld = 1'b0;
    @(negedge clk);
    chk("R7 odd unchanged after done", 32'(ecc0_o), 32'(o0));
    chk("R7 even unchanged after done", 32'(ecc1_o), 32'(h0));
    chk("R7 done stays high", 32'(page_done), 32'd1);

    // R8: clear mid-page together with a strobe drops that byte
    wide_page = 1'b0;
    pulse_clr();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); byte_vld = 1'b1; byte_data = 8'h3C;
    end
    ecc_clr = 1'b1; byte_data = 8'hFF;
    @(negedge clk);
    ecc_clr = 1'b0; byte_vld = 1'b0;
    chk("R8 clear zeroes ecc0", 32'(ecc0_o), 32'd0);
    chk("R8 clear zeroes ecc1", 32'(ecc1_o), 32'd0);
    chk("R8 clear drops done", 32'(page_done), 32'd0);
    // byte 0 after clear is the first byte of the page
    for (int i = 0; i < 512; i++) pg[i] = 8'h00;
    @(negedge clk); byte_vld = 1'b1; byte_data = 8'h80;  // byte 0 bit 7
    @(negedge clk); byte_vld = 1'b0;
    chk("R8 restart at byte 0 odd", 32'(ecc0_o), 32'd7);
    chk("R8 restart at byte 0 even", 32'(ecc1_o), 32'h7F8);

    repeat (3) @(negedge clk);
    chk("scoreboard drained", 32'(sb_q.size()), 32'd0);
    finish_up();
  end

endmodule